// File: doc/BRIEF.md
# E1 Error Counter Bank with Maskable Interrupts

This block keeps three performance-monitoring counts for an E1 receive path: frame-alignment-word errors (8 bits), far-end block errors reported through E-bits (16 bits) and CRC-4 check failures (16 bits). An external framer delivers each error as a one-cycle pulse. The block only counts: framing, CRC-4 computation and error detection all happen elsewhere. Each counter wraps through zero. Software can read any counter, or load it with a preset value or zero, through a plain register port. Reads are combinational and writes are single-cycle strobes with no back-pressure.

Every counter feeds two interrupt sources. The activity source fires each time counting changes the counter's least significant bit. The overflow source fires when the counter rolls from all ones to zero. The six sources latch into sticky status bits, which software clears by writing ones. A mask register gates each source onto one level-sensitive interrupt output. A masked source still records its status bit.

Top module: `e1_errcnt_bank`

## Requirements
- R1: After reset all three counts, the status register and the interrupt output are zero, and the mask register reads 0x3F (every source masked).
- R2: Each cycle in which an error pulse is high adds one to its counter, modulo 2^8 for the frame-alignment counter and 2^16 for the E-bit and CRC-4 counters. Pulses on consecutive cycles are each counted, and pulses on different counters in the same cycle are independent.
- R3: Register map by `reg_addr`: 0 frame-alignment count (bits 7:0, upper bits read 0), 1 E-bit count, 2 CRC-4 count, 3 status, 4 mask. Any other address reads 0. `reg_rdata` follows `reg_addr` without a clock.
- R4: A write to a counter address loads bits of `reg_wdata` into that counter at the next edge. An error pulse for the same counter in the same cycle is discarded.
- R5: Status bit positions: [0] frame-alignment activity, [1] frame-alignment overflow, [2] E-bit activity, [3] E-bit overflow, [4] CRC-4 activity, [5] CRC-4 overflow. An increment sets its activity bit, visible after the second rising edge following the pulse.
- R6: The overflow bit of a counter is set only by the increment that takes it from all ones (0xFF or 0xFFFF) to zero.
- R7: A software load never sets an activity or overflow bit, even when it changes the least significant bit.
- R8: Status bits are sticky. Writing to address 3 clears each bit written as 1 and leaves bits written as 0. A new event arriving in the same cycle as its clear leaves the bit set.
- R9: `irq` is high exactly while some status bit is set whose mask bit (same position, address 4) is 0. A mask bit of 1 keeps its source off `irq` but not out of the status register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| fas_err | input | 1 | Frame-alignment error pulse |
| ebit_err | input | 1 | E-bit error pulse |
| crc_err | input | 1 | CRC-4 error pulse |
| reg_addr | input | 3 | Register address |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| irq | output | 1 | Combined unmasked interrupt |

## Verification
The hardest cases to produce from the ports are collisions. One is a status clear that lands on the same edge as a new activity event for that bit. The other is a counter load that coincides with an increment. The event reaches the status register one edge after the counter changes. The bench therefore raises the error pulse at one falling edge and issues the clear at the next, so both meet on the second rising edge. For the load collision, it drives the pulse and the write strobe together in a single cycle. It also presets counters to one below the wrap point, so that overflow is reached in one or two pulses instead of thousands.

// File: rtl/e1_errcnt_pkg.sv
package e1_errcnt_pkg;
  localparam int NUM_CNT    = 3;
  localparam int ST_W       = 2 * NUM_CNT;
  localparam int REG_ADDR_W = 3;

  typedef enum logic [REG_ADDR_W-1:0] {
    ADR_FAS  = 3'd0,
    ADR_EBIT = 3'd1,
    ADR_CRC  = 3'd2,
    ADR_STAT = 3'd3,
    ADR_MASK = 3'd4
  } reg_adr_e;

  localparam logic [ST_W-1:0] MASK_RST = '1;
endpackage

// File: rtl/errcnt_unit.sv
module errcnt_unit #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         inc_i,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  output logic [W-1:0] count_o,
  output logic         act_o,
  output logic         ovf_o
);
  logic [W-1:0] count_q;
  logic         lsb_seen_q;
  logic         wrap_q;

  // A load aligns the remembered LSB with the new value so no toggle is seen.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      count_q    <= '0;
      lsb_seen_q <= 1'b0;
      wrap_q     <= 1'b0;
    end else if (load_i) begin
      count_q    <= load_val_i;
      lsb_seen_q <= load_val_i[0];
      wrap_q     <= 1'b0;
    end else begin
      lsb_seen_q <= count_q[0];
      if (inc_i) begin
        count_q <= count_q + W'(1);
        wrap_q  <= &count_q;
      end else begin
        wrap_q  <= 1'b0;
      end
    end
  end

  assign count_o = count_q;
  assign act_o   = count_q[0] ^ lsb_seen_q;
  assign ovf_o   = wrap_q;

  AST_LOAD_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> count_o == $past(load_val_i)); // R4
  AST_INC_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (inc_i && !load_i) |=> count_o == $past(count_o) + W'(1)); // R2
  AST_WRAP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_o |-> count_o == '0); // R6
  AST_LOAD_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (!act_o && !ovf_o)); // R7
endmodule

// File: rtl/errcnt_irq.sv
module errcnt_irq #(
  parameter int               N        = 6,
  parameter logic [N-1:0]     MASK_RST = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] ev_i,
  input  logic [N-1:0] clr_i,
  input  logic         mask_wr_i,
  input  logic [N-1:0] mask_val_i,
  output logic [N-1:0] status_o,
  output logic [N-1:0] mask_o,
  output logic         irq_o
);
  logic [N-1:0] status_q;
  logic [N-1:0] mask_q;

  // Set beats clear: the event term is ORed after the clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      status_q <= '0;
      mask_q   <= MASK_RST;
    end else begin
      status_q <= (status_q & ~clr_i) | ev_i;
      if (mask_wr_i) mask_q <= mask_val_i;
    end
  end

  assign status_o = status_q;
  assign mask_o   = mask_q;
  assign irq_o    = |(status_q & ~mask_q);

  AST_STATUS_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_i != '0) |=> ((status_o & $past(ev_i)) == $past(ev_i))); // R5
  AST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (status_o != '0) |=> ((status_o & $past(status_o & ~clr_i)) == $past(status_o & ~clr_i))); // R8
  AST_MASK_ALL_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mask_o == '1) |-> !irq_o); // R9
endmodule

// File: rtl/errcnt_regif.sv
module errcnt_regif
  import e1_errcnt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic                             clk,
  input  logic                             rst_n,
  input  logic                             wr_i,
  input  logic [REG_ADDR_W-1:0]            addr_i,
  input  logic [DATA_W-1:0]                wdata_i,
  input  logic [NUM_CNT-1:0][DATA_W-1:0]   cnt_i,
  input  logic [ST_W-1:0]                  status_i,
  input  logic [ST_W-1:0]                  mask_i,
  output logic [NUM_CNT-1:0]               load_o,
  output logic [ST_W-1:0]                  clr_o,
  output logic                             mask_wr_o,
  output logic [DATA_W-1:0]                rdata_o
);
  // Counters occupy addresses 0 .. NUM_CNT-1 in index order.
  for (genvar i = 0; i < NUM_CNT; i++) begin : g_load
    assign load_o[i] = wr_i && (addr_i == REG_ADDR_W'(i));
  end

  assign clr_o     = (wr_i && addr_i == ADR_STAT) ? wdata_i[ST_W-1:0] : '0;
  assign mask_wr_o = wr_i && (addr_i == ADR_MASK);

  always_comb begin
    rdata_o = '0;
    case (addr_i)
      ADR_FAS:  rdata_o = cnt_i[0];
      ADR_EBIT: rdata_o = cnt_i[1];
      ADR_CRC:  rdata_o = cnt_i[2];
      ADR_STAT: rdata_o = DATA_W'(status_i);
      ADR_MASK: rdata_o = DATA_W'(mask_i);
      default:  rdata_o = '0;
    endcase
  end

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({load_o, mask_wr_o, clr_o != '0})); // R3
endmodule

// File: rtl/e1_errcnt_bank.sv
module e1_errcnt_bank
  import e1_errcnt_pkg::*;
#(
  parameter int FAS_W  = 8,
  parameter int EBIT_W = 16,
  parameter int CRC_W  = 16,
  parameter int DATA_W = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  fas_err,
  input  logic                  ebit_err,
  input  logic                  crc_err,
  input  logic [REG_ADDR_W-1:0] reg_addr,
  input  logic                  reg_wr,
  input  logic [DATA_W-1:0]     reg_wdata,
  output logic [DATA_W-1:0]     reg_rdata,
  output logic                  irq
);
  logic [NUM_CNT-1:0]             inc;
  logic [NUM_CNT-1:0]             load;
  logic [NUM_CNT-1:0][DATA_W-1:0] cnt_ext;
  logic [ST_W-1:0]                ev;
  logic [ST_W-1:0]                clr;
  logic [ST_W-1:0]                status;
  logic [ST_W-1:0]                mask;
  logic                           mask_wr;

  assign inc = {crc_err, ebit_err, fas_err};

  for (genvar i = 0; i < NUM_CNT; i++) begin : g_cnt
    localparam int W = (i == 0) ? FAS_W : ((i == 1) ? EBIT_W : CRC_W);
    logic [W-1:0] cnt;
    errcnt_unit #(.W(W)) u_unit (
      .clk        (clk),
      .rst_n      (rst_n),
      .inc_i      (inc[i]),
      .load_i     (load[i]),
      .load_val_i (reg_wdata[W-1:0]),
      .count_o    (cnt),
      .act_o      (ev[2*i]),
      .ovf_o      (ev[2*i+1])
    );
    assign cnt_ext[i] = DATA_W'(cnt);
  end

  errcnt_regif #(.DATA_W(DATA_W)) u_regif (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_i      (reg_wr),
    .addr_i    (reg_addr),
    .wdata_i   (reg_wdata),
    .cnt_i     (cnt_ext),
    .status_i  (status),
    .mask_i    (mask),
    .load_o    (load),
    .clr_o     (clr),
    .mask_wr_o (mask_wr),
    .rdata_o   (reg_rdata)
  );

  errcnt_irq #(.N(ST_W), .MASK_RST(MASK_RST)) u_irq (
    .clk        (clk),
    .rst_n      (rst_n),
    .ev_i       (ev),
    .clr_i      (clr),
    .mask_wr_i  (mask_wr),
    .mask_val_i (reg_wdata[ST_W-1:0]),
    .status_o   (status),
    .mask_o     (mask),
    .irq_o      (irq)
  );

  AST_OVF_NEEDS_ACT: assert property (@(posedge clk) disable iff (!rst_n)
    ev[1] |-> ev[0]); // R6
endmodule

// File: tb/e1_errcnt_bank_bench.sv
module e1_errcnt_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fas_err = 1'b0, ebit_err = 1'b0, crc_err = 1'b0;
  logic [2:0]  reg_addr = '0;
  logic        reg_wr = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic        irq;
  int          nvec = 0, nbad = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  e1_errcnt_bank u_e1_errcnt_bank (
    .clk(clk), .rst_n(rst_n), .fas_err(fas_err), .ebit_err(ebit_err),
    .crc_err(crc_err), .reg_addr(reg_addr), .reg_wr(reg_wr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
  );

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    nvec++;
    if (got !== exp) begin
      nbad++;
      $display("FAIL %s actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [15:0] d);
    @(negedge clk); reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [15:0] d);
    @(negedge clk); reg_addr = a; #1; d = reg_rdata;
  endtask

  task automatic pulse(input logic [2:0] which);
    @(negedge clk); {crc_err, ebit_err, fas_err} = which;
    @(negedge clk); {crc_err, ebit_err, fas_err} = 3'b000;
  endtask

  task automatic t_reset();
    logic [15:0] d;
    rd(3'd0, d); check("R1 fas count", d, 16'h0000);
    rd(3'd1, d); check("R1 ebit count", d, 16'h0000);
    rd(3'd2, d); check("R1 crc count", d, 16'h0000);
    rd(3'd3, d); check("R1 status", d, 16'h0000);
    rd(3'd4, d); check("R1 mask", d, 16'h003F);
    check("R1 irq", {15'd0, irq}, 16'h0000);
  endtask

  task automatic t_count();
    logic [15:0] d;
    repeat (3) pulse(3'b001);
    rd(3'd0, d); check("R2 fas three pulses", d, 16'h0003);
    rd(3'd1, d); check("R2 ebit untouched", d, 16'h0000);
  endtask

  task automatic t_back_to_back();
    logic [15:0] d;
    @(negedge clk); ebit_err = 1'b1; crc_err = 1'b1;
    repeat (3) @(negedge clk);
    ebit_err = 1'b0; crc_err = 1'b0;
    rd(3'd1, d); check("R2 ebit consecutive", d, 16'h0003);
    rd(3'd2, d); check("R2 crc consecutive", d, 16'h0003);
  endtask

  task automatic t_fas_wrap();
    logic [15:0] d;
    wr(3'd0, 16'h00FE);
    wr(3'd3, 16'h003F);
    pulse(3'b001);
    rd(3'd0, d); check("R2 fas to FF", d, 16'h00FF);
    rd(3'd3, d); check("R6 no overflow below wrap", d, 16'h0001);
    wr(3'd3, 16'h003F);
    pulse(3'b001);
    rd(3'd0, d); check("R6 fas wraps to 0", d, 16'h0000);
    rd(3'd3, d); check("R6 fas overflow bit", d, 16'h0003);
  endtask

  task automatic t_crc_wrap();
    logic [15:0] d;
    wr(3'd2, 16'hFFFF);
    wr(3'd3, 16'h003F);
    pulse(3'b100);
    rd(3'd2, d); check("R6 crc wraps to 0", d, 16'h0000);
    rd(3'd3, d); check("R6 R5 crc act and overflow", d, 16'h0030);
  endtask

  task automatic t_write_priority();
    logic [15:0] d;
    wr(3'd3, 16'h003F);
    @(negedge clk); reg_addr = 3'd1; reg_wdata = 16'h1234; reg_wr = 1'b1; ebit_err = 1'b1;
    @(negedge clk); reg_wr = 1'b0; ebit_err = 1'b0;
    rd(3'd1, d); check("R4 load beats increment", d, 16'h1234);
    wr(3'd0, 16'h0001);
    rd(3'd3, d); check("R7 loads set no status", d, 16'h0000);
  endtask

  task automatic t_map();
    logic [15:0] d;
    wr(3'd0, 16'hABCD);
    rd(3'd0, d); check("R3 fas upper bits zero", d, 16'h00CD);
    rd(3'd5, d); check("R3 unmapped addr 5", d, 16'h0000);
    rd(3'd7, d); check("R3 unmapped addr 7", d, 16'h0000);
  endtask

  task automatic t_w1c();
    logic [15:0] d;
    wr(3'd3, 16'h003F);
    pulse(3'b101);
    rd(3'd3, d); check("R5 fas and crc act", d, 16'h0011);
    wr(3'd3, 16'h0001);
    rd(3'd3, d); check("R8 clear one bit", d, 16'h0010);
    wr(3'd3, 16'h0000);
    rd(3'd3, d); check("R8 zero write keeps", d, 16'h0010);
  endtask

  task automatic t_set_wins();
    logic [15:0] d;
    wr(3'd3, 16'h003F);
    @(negedge clk); ebit_err = 1'b1;
    @(negedge clk); ebit_err = 1'b0; reg_addr = 3'd3; reg_wdata = 16'h0004; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
    rd(3'd3, d); check("R8 set wins over clear", d, 16'h0004);
  endtask

  task automatic t_mask();
    logic [15:0] d;
    wr(3'd3, 16'h003F);
    wr(3'd4, 16'h003F);
    pulse(3'b010);
    rd(3'd3, d); check("R9 masked source sets status", d, 16'h0004);
    check("R9 masked irq low", {15'd0, irq}, 16'h0000);
    wr(3'd4, 16'h003B);
    rd(3'd4, d); check("R3 mask readback", d, 16'h003B);
    check("R9 unmasked irq high", {15'd0, irq}, 16'h0001);
    wr(3'd3, 16'h0004);
    rd(3'd3, d);
    check("R9 irq low after clear", {15'd0, irq}, 16'h0000);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_count();
    t_back_to_back();
    t_fas_wrap();
    t_crc_wrap();
    t_write_priority();
    t_map();
    t_w1c();
    t_set_wins();
    t_mask();
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      nvec++;
      nbad++;
      $display("FAIL watchdog R1-path run hung actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
      $finish;
    end
  end
endmodule